// File: doc/BRIEF.md
# Battery-Domain Seconds Counter

A real-time counter kept in a slow, always-on clock domain running at 32768 Hz. It holds a 47-bit count that software treats as a fixed-point seconds value: the 15 least significant bits are fractions of a second and the upper 32 bits are whole seconds. A 32-bit register interface on a separate, much faster bus clock reads the count through a high word and a low word. The same interface sets a run bit and an optional calibration that adjusts the rate once per calibration period.

The run bit is a handshake across the two clock domains. Software writes the request, and the bit it reads back shows the state the slow domain has actually reached, so a read taken straight after a write still returns the old state. Software sets a new count in four steps: it stops the counter, waits for the read-back to show it stopped, writes both count words, then starts the counter again. The new value takes effect on the slow edge that sees the start, and the count first advances two slow edges after that. The two count words are not captured together, so software reads the pair twice until both reads agree.

Top module: `rtc_seconds_counter`

## Requirements
- R1: After reset the control, count-high and count-low registers all read zero.
- R2: The control register is at offset 0x38. Bit 0 requests counting, bit 8 enables calibration and bits 14:10 hold the 5-bit calibration value. Bits 8 and 14:10 read back as last written, and every other bit except bit 0 reads zero.
- R3: Control bit 0 reads the run state acknowledged by the slow domain. The bus read in the cycle after a write still returns the old state, and the new state appears within a few slow cycles.
- R4: While running with calibration off, the count rises by exactly one on each slow clock edge. While stopped it holds its value.
- R5: Offset 0x50 returns count bits 46:32 in bits 14:0, with bits 31:15 reading zero. Offset 0x54 returns count bits 31:0.
- R6: A write to 0x50 or 0x54 while the counter is stopped and acknowledged stopped stages that word. The next start loads the staged value. A start with no new staged write resumes from the held count.
- R7: Writes to 0x50 or 0x54 are ignored while counting is requested or still acknowledged.
- R8: On the slow edge that loads or resumes the count, the count keeps its value for one further edge. The first increment comes on the second slow edge after the load.
- R9: The count wraps from all ones to zero.
- R10: With calibration enabled, the 5-bit value is two's complement (range -16 to +15). On every 2^CAL_LOG2-th tick after a start, that value is added on top of the normal increment. With calibration disabled the value has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Register interface clock |
| slowClk | input | 1 | 32768 Hz counting clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| regWrEn | input | 1 | Register write strobe, one bus cycle per write |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed register, combinational |

## Verification
Every cycle, the assertions check the following in the slow domain: the count holds while stopped, rises by exactly one per edge while running uncalibrated, and holds for the extra edge after a load. On the bus side they check that the staged load value never moves while counting is locked. They also check that the bus-side count mirror changes only when a fresh snapshot arrives. Only the bench scenarios can show whole-sequence behaviour: the lag of the acknowledged bit, that a stopped-then-started counter resumes instead of reloading, that writes made while running are dropped, wrap-around, and the net rate under positive, negative and disabled calibration over many periods.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Bus-side decode results handed from the register control to the datapath
  typedef struct packed {
    logic ctrlWr;
    logic hiWr;
    logic loWr;
  } rtc_strobe_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_HI   = 2'd2,
    RD_LO   = 2'd3
  } rtc_rdsel_t;

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/rtc_reg_ctrl.sv
module rtc_reg_ctrl
  import rtc_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h38,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h50,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h54
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock,
  output rtc_strobe_t       stb,
  output rtc_rdsel_t        rdSel
);

  logic hitCtrl, hitHi, hitLo;

  always_comb begin
    hitCtrl = (addr == CTRL_ADDR);
    hitHi   = (addr == HI_ADDR);
    hitLo   = (addr == LO_ADDR);

    stb.ctrlWr = wrEn && hitCtrl;
    // count words are only staged while both request and acknowledge are low
    stb.hiWr   = wrEn && hitHi && !lock;
    stb.loWr   = wrEn && hitLo && !lock;

    if (hitCtrl)    rdSel = RD_CTRL;
    else if (hitHi) rdSel = RD_HI;
    else if (hitLo) rdSel = RD_LO;
    else            rdSel = RD_NONE;
  end

endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_pkg::*;
#(
  parameter int COUNT_W    = 47,
  parameter int CAL_W      = 5,
  parameter int EN_BIT     = 0,
  parameter int CALEN_BIT  = 8,
  parameter int CALVAL_LSB = 10
) (
  input  logic               busClk,
  input  logic               rstN,
  input  rtc_strobe_t        stb,
  input  rtc_rdsel_t         rdSel,
  input  logic [31:0]        wrData,
  input  logic               enAckAsync,
  input  logic               pubTogAsync,
  input  logic [COUNT_W-1:0] pubCountAsync,
  output logic               enReq,
  output logic               calEn,
  output logic [CAL_W-1:0]   calVal,
  output logic [COUNT_W-1:0] stage,
  output logic               loadArm,
  output logic               lock,
  output logic [31:0]        rdData
);

  localparam int HI_W = COUNT_W - 32;

  logic               ackSync;
  logic               togSync;
  logic               togPrev;
  logic               togEdge;
  logic [COUNT_W-1:0] shadow;

  rtc_sync #(.W(2)) u_backSync (
    .clk  (busClk),
    .rstN (rstN),
    .d    ({enAckAsync, pubTogAsync}),
    .q    ({ackSync, togSync})
  );

  assign togEdge = togSync ^ togPrev;
  assign lock    = enReq | ackSync;

  // control fields and load staging
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      enReq   <= 1'b0;
      calEn   <= 1'b0;
      calVal  <= '0;
      stage   <= '0;
      loadArm <= 1'b0;
    end else begin
      if (stb.ctrlWr) begin
        enReq  <= wrData[EN_BIT];
        calEn  <= wrData[CALEN_BIT];
        calVal <= wrData[CALVAL_LSB +: CAL_W];
      end
      if (ackSync) loadArm <= 1'b0;
      if (stb.hiWr) begin
        stage[COUNT_W-1:32] <= wrData[HI_W-1:0];
        loadArm             <= 1'b1;
      end
      if (stb.loWr) begin
        stage[31:0] <= wrData;
        loadArm     <= 1'b1;
      end
    end
  end

  // mirror of the slow count, captured once per published snapshot
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      togPrev <= 1'b0;
      shadow  <= '0;
    end else begin
      togPrev <= togSync;
      if (togEdge) shadow <= pubCountAsync;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_CTRL: begin
        rdData[EN_BIT]                = ackSync;
        rdData[CALEN_BIT]             = calEn;
        rdData[CALVAL_LSB +: CAL_W]   = calVal;
      end
      RD_HI:   rdData[HI_W-1:0] = shadow[COUNT_W-1:32];
      RD_LO:   rdData           = shadow[31:0];
      default: rdData = '0;
    endcase
  end

  AST_STAGE_LOCKED: assert property (@(posedge busClk) disable iff (!rstN)
    lock |=> $stable(stage)); // R7

  AST_SHADOW_ON_SNAPSHOT: assert property (@(posedge busClk) disable iff (!rstN)
    !togEdge |=> $stable(shadow)); // R5

endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core #(
  parameter int COUNT_W  = 47,
  parameter int CAL_W    = 5,
  parameter int CAL_LOG2 = 15
) (
  input  logic               slowClk,
  input  logic               rstN,
  input  logic               enReqAsync,
  input  logic               calEnAsync,
  input  logic [CAL_W-1:0]   calValAsync,
  input  logic [COUNT_W-1:0] stageAsync,
  input  logic               loadArmAsync,
  output logic               enAck,
  output logic               pubTog,
  output logic [COUNT_W-1:0] pubCount
);

  localparam int SYNC_W = 3 + CAL_W + COUNT_W;

  logic                 enSync;
  logic                 calEnS;
  logic [CAL_W-1:0]     calValS;
  logic [COUNT_W-1:0]   stageS;
  logic                 loadArmS;
  logic                 enPrev;
  logic                 startWait;
  logic [COUNT_W-1:0]   count;
  logic [CAL_LOG2-1:0]  calPhase;
  logic signed [CAL_W:0] calStep;
  logic [COUNT_W-1:0]   stepVal;
  logic                 startEdge;

  rtc_sync #(.W(SYNC_W)) u_fwdSync (
    .clk  (slowClk),
    .rstN (rstN),
    .d    ({enReqAsync, calEnAsync, loadArmAsync, calValAsync, stageAsync}),
    .q    ({enSync, calEnS, loadArmS, calValS, stageS})
  );

  assign startEdge = enSync && !enPrev;

  // calibration: two's complement value added on top of the normal +1
  always_comb begin
    calStep = $signed({calValS[CAL_W-1], calValS}) + $signed({{CAL_W{1'b0}}, 1'b1});
    if (calEnS && (&calPhase))
      stepVal = {{(COUNT_W-CAL_W-1){calStep[CAL_W]}}, calStep};
    else
      stepVal = {{(COUNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      enPrev    <= 1'b0;
      enAck     <= 1'b0;
      startWait <= 1'b0;
      count     <= '0;
      calPhase  <= '0;
    end else begin
      enPrev <= enSync;
      enAck  <= enSync;
      if (startEdge) begin
        if (loadArmS) count <= stageS;
        startWait <= 1'b1;
        calPhase  <= '0;
      end else if (enSync && startWait) begin
        startWait <= 1'b0;
      end else if (enSync) begin
        count    <= count + stepVal;
        calPhase <= calPhase + 1'b1;
      end
    end
  end

  // snapshot published to the bus side, refreshed every slow cycle
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      pubTog   <= 1'b0;
      pubCount <= '0;
    end else begin
      pubTog   <= ~pubTog;
      pubCount <= count;
    end
  end

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge slowClk) disable iff (!rstN)
    !enSync |=> $stable(count)); // R4

  AST_START_GAP: assert property (@(posedge slowClk) disable iff (!rstN)
    startWait |=> $stable(count)); // R8

  AST_UNIT_STEP: assert property (@(posedge slowClk) disable iff (!rstN)
    (enSync && enPrev && !startWait && !calEnS) |=> (count == $past(count) + 1'b1)); // R4

endmodule

// File: rtl/rtc_seconds_counter.sv
module rtc_seconds_counter
  import rtc_pkg::*;
#(
  parameter int COUNT_W  = 47,
  parameter int CAL_W    = 5,
  parameter int CAL_LOG2 = 15
) (
  input  logic        busClk,
  input  logic        slowClk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);

  rtc_strobe_t        stb;
  rtc_rdsel_t         rdSel;
  logic               lock;
  logic               enReq;
  logic               calEn;
  logic [CAL_W-1:0]   calVal;
  logic [COUNT_W-1:0] stage;
  logic               loadArm;
  logic               enAck;
  logic               pubTog;
  logic [COUNT_W-1:0] pubCount;

  rtc_reg_ctrl #(.ADDR_W(8)) u_ctrl (
    .wrEn  (regWrEn),
    .addr  (regAddr),
    .lock  (lock),
    .stb   (stb),
    .rdSel (rdSel)
  );

  rtc_bus_regs #(.COUNT_W(COUNT_W), .CAL_W(CAL_W)) u_regs (
    .busClk        (busClk),
    .rstN          (rstN),
    .stb           (stb),
    .rdSel         (rdSel),
    .wrData        (regWrData),
    .enAckAsync    (enAck),
    .pubTogAsync   (pubTog),
    .pubCountAsync (pubCount),
    .enReq         (enReq),
    .calEn         (calEn),
    .calVal        (calVal),
    .stage         (stage),
    .loadArm       (loadArm),
    .lock          (lock),
    .rdData        (regRdData)
  );

  rtc_slow_core #(.COUNT_W(COUNT_W), .CAL_W(CAL_W), .CAL_LOG2(CAL_LOG2)) u_core (
    .slowClk      (slowClk),
    .rstN         (rstN),
    .enReqAsync   (enReq),
    .calEnAsync   (calEn),
    .calValAsync  (calVal),
    .stageAsync   (stage),
    .loadArmAsync (loadArm),
    .enAck        (enAck),
    .pubTog       (pubTog),
    .pubCount     (pubCount)
  );

endmodule

// File: tb/rtc_seconds_counter_tb.sv
module rtc_seconds_counter_tb;

  localparam int BUS_PERIOD  = 10;
  localparam int SLOW_PERIOD = 74;
  localparam int CAL_LOG2    = 4;
  localparam int CAL_PERIOD  = 1 << CAL_LOG2;
  localparam logic [7:0] A_CTRL = 8'h38;
  localparam logic [7:0] A_HI   = 8'h50;
  localparam logic [7:0] A_LO   = 8'h54;

  logic        busClk = 1'b0;
  logic        slowClk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(BUS_PERIOD/2) busClk = ~busClk;
  always #(SLOW_PERIOD/2) slowClk = ~slowClk;

  rtc_seconds_counter #(.CAL_LOG2(CAL_LOG2)) u_dut (
    .busClk    (busClk),
    .slowClk   (slowClk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData)
  );

  // expected count change after t ticks, calibration from the start point
  function automatic logic [46:0] model(int t, bit ce, logic [4:0] cv);
    logic [46:0] d;
    logic signed [5:0] s;
    int ph;
    d = '0;
    ph = 0;
    s = $signed({cv[4], cv}) + 6'sd1;
    for (int i = 0; i < t; i++) begin
      if (ce && ph == CAL_PERIOD - 1) d = d + {{41{s[5]}}, s};
      else d = d + 47'd1;
      ph = (ph + 1) % CAL_PERIOD;
    end
    return d;
  endfunction

  function automatic logic [31:0] ctrlWord(bit en, bit ce, logic [4:0] cv);
    return {17'b0, cv, 1'b0, ce, 7'b0, en};
  endfunction

  task automatic chkEq(string req, string what, longint unsigned act, longint unsigned exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge busClk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge busClk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge busClk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic readCount(output logic [46:0] c);
    logic [31:0] h1, l1, h2, l2;
    for (int k = 0; k < 10; k++) begin
      rd(A_HI, h1); rd(A_LO, l1); rd(A_HI, h2); rd(A_LO, l2);
      if (h1 == h2 && l1 == l2) break;
    end
    c = {h2[14:0], l2};
  endtask

  task automatic pollAck(input bit v, output bit ok);
    logic [31:0] r;
    ok = 1'b0;
    for (int k = 0; k < 80; k++) begin
      rd(A_CTRL, r);
      if (r[0] == v) begin ok = 1'b1; break; end
    end
  endtask

  // start (optionally after staging base), run, stop, check the count window
  task automatic runSpan(input logic [46:0] base, input bit doLoad, input int m,
                         input bit ce, input logic [4:0] cv, input bit junk,
                         output logic [46:0] c);
    logic [31:0] r;
    logic [46:0] delta;
    bit ok;
    bit hit;
    if (doLoad) begin
      wr(A_HI, {17'b0, base[46:32]});
      wr(A_LO, base[31:0]);
    end
    wr(A_CTRL, ctrlWord(1'b1, ce, cv));
    rd(A_CTRL, r);
    chkEq("R3", "ack right after enable write", r[0], 0);
    pollAck(1'b1, ok);
    chkEq("R3", "ack reaches running", ok, 1);
    repeat (2) @(posedge slowClk);
    repeat (5) @(negedge busClk);
    rd(A_LO, r);
    chkEq("R8", "low word held through start gap", r, base[31:0]);
    if (junk) begin
      wr(A_HI, 32'h0000_5A5A);
      wr(A_LO, 32'hDEAD_BEEF);
    end
    repeat (m) @(posedge slowClk);
    wr(A_CTRL, ctrlWord(1'b0, ce, cv));
    pollAck(1'b0, ok);
    chkEq("R3", "ack reaches stopped", ok, 1);
    repeat (40) @(negedge busClk);
    readCount(c);
    rd(A_HI, r);
    chkEq("R5", "high word upper bits zero", r[31:15], 0);
    delta = c - base;
    hit = 1'b0;
    for (int t = m; t <= m + 6; t++) if (model(t, ce, cv) == delta) hit = 1'b1;
    nChecks++;
    if (!hit) begin
      nFail++;
      $display("FAIL R4/R10 count window actual=%0h expected=%0h..%0h",
               delta, model(m, ce, cv), model(m + 6, ce, cv));
    end
  endtask

  initial begin
    #(BUS_PERIOD * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [46:0] c, c2, base;
    logic [4:0] cv;
    bit ce;
    int m;
    void'($urandom(32'd20240611));

    repeat (20) @(negedge busClk);
    rstN = 1'b1;
    repeat (5) @(negedge busClk);

    // R1 reset state
    rd(A_CTRL, r); chkEq("R1", "control after reset", r, 0);
    rd(A_HI, r);   chkEq("R1", "high after reset", r, 0);
    rd(A_LO, r);   chkEq("R1", "low after reset", r, 0);

    // R2 control field readback
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd(A_CTRL, r); chkEq("R2", "control readback", r, 32'h0000_7D00);
    wr(A_CTRL, ctrlWord(1'b0, 1'b0, 5'h0A));
    rd(A_CTRL, r); chkEq("R2", "control readback value only", r, 32'h0000_2800);
    wr(A_CTRL, 32'h0);

    // R6 load and R4 basic count, then R7 ignored writes while running
    base = 47'h1234_5678_9ABC;
    runSpan(base, 1'b1, 30, 1'b0, 5'h0, 1'b1, c);
    // R6 resume without new write: must not reload base or junk
    runSpan(c, 1'b0, 25, 1'b0, 5'h0, 1'b0, c2);
    // R4 hold while stopped
    repeat (300) @(negedge busClk);
    readCount(c);
    chkEq("R4", "count holds while stopped", c, c2);

    // R9 wrap
    base = 47'h7FFF_FFFF_FFF8;
    runSpan(base, 1'b1, 20, 1'b0, 5'h0, 1'b0, c);
    chkEq("R9", "count wrapped below 32", c < 47'd32, 1);

    // R10 calibration corners
    runSpan(47'h100, 1'b1, 70, 1'b1, 5'h0F, 1'b0, c);   // +15
    runSpan(47'h200, 1'b1, 70, 1'b1, 5'h10, 1'b0, c);   // -16
    runSpan(47'h300, 1'b1, 70, 1'b0, 5'h0F, 1'b0, c);   // disabled: no effect
    chkEq("R10", "disabled calibration leaves plain rate", (c - 47'h300) <= 47'd76, 1);

    // random mix
    for (int it = 0; it < 6; it++) begin
      base = {$urandom() & 32'h7FFF, $urandom()};
      m = 10 + ($urandom() % 40);
      ce = $urandom() % 2;
      cv = $urandom() % 32;
      runSpan(base, 1'b1, m, ce, cv, ($urandom() % 2) == 1, c);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule